// File: doc/BRIEF.md
# Four-Beat Burst Address Generator

This block produces the word addresses for a synchronous SRAM burst. One start address is captured, and from it four word addresses follow in turn. Only the two least-significant bits move through the burst. The upper bits always come from the captured start address.

A load/advance control picks the action on each enabled clock edge. When it is low, a new external address is captured and the beat counter restarts at zero. When it is high, the 2-bit beat counter steps by one. A static order input selects how the counter is applied to the low start bits. In linear order the counter is added modulo four. In interleaved order the counter is XORed with the start bits. A clock enable freezes all internal state.

The output address is decoded combinationally from the registered start address and the registered counter. It therefore changes on the clock edge that captures the new state. All pins are plain control and address pins. Nothing flows as a stream, so there is no valid/ready handshake and no back-pressure.

Top module: `addr_burst_gen`

## Requirements
- R1: While `rst_n` is low, and after it is released with no enabled edge yet, `burst_addr` is 0.
- R2: On an edge with `clk_en`=1 and `advance`=0, `ext_addr` is captured, and `burst_addr` equals `ext_addr` from that edge on.
- R3: With `order_xor`=0, each edge with `clk_en`=1 and `advance`=1 makes the low two bits of `burst_addr` equal (start low bits + beat count) mod 4. Starting at 1, this gives 1,2,3,0.
- R4: With `order_xor`=1, the low two bits of `burst_addr` are (start low bits XOR beat count). Starting at 1, this gives 1,0,3,2.
- R5: After the fourth beat, the next advance returns `burst_addr` to the first address of the burst.
- R6: Advancing never changes bits ADDR_W-1..2 of `burst_addr`. There is no carry out of the low two bits.
- R7: On an edge with `clk_en`=0, `ext_addr` and `advance` have no effect, and `burst_addr` keeps its value.
- R8: A load in the middle of a burst restarts the beat count at zero on the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | 1 = edge acts, 0 = all state holds |
| advance | input | 1 | 0 = capture ext_addr, 1 = step beat counter |
| order_xor | input | 1 | Static order select: 0 linear, 1 interleaved |
| ext_addr | input | ADDR_W | External start address |
| burst_addr | output | ADDR_W | Current burst word address |

## Verification
The assertions check four properties on every cycle. A load reproduces the presented address. A frozen edge leaves the output unchanged. An advance never disturbs the upper bits. In linear order, each advance steps the low bits by exactly one.

The interleaved sequence, the return to the first address after four beats, a restart in mid-burst and the reset value are shown only by the bench. It compares full expected address sequences for chosen start values in both orders.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int BEAT_W = 2;
  typedef logic [BEAT_W-1:0] beat_t;
endpackage

// File: rtl/burst_beat_counter.sv
module burst_beat_counter
  import burst_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  logic  restart,
  output beat_t beat
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       beat <= '0;
    else if (en) begin
      if (restart)    beat <= '0;
      else            beat <= beat + beat_t'(1);
    end
  end
endmodule

// File: rtl/burst_start_reg.sv
module burst_start_reg #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [ADDR_W-1:0] d,
  output logic [ADDR_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= '0;
    else if (capture) q <= d;
  end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
(
  input  beat_t start_lo,
  input  beat_t beat,
  input  logic  order_xor,
  output beat_t addr_lo
);
  beat_t lin_lo;
  beat_t ilv_lo;
  assign lin_lo = start_lo + beat;
  for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
    assign ilv_lo[b] = start_lo[b] ^ beat[b];
  end
  assign addr_lo = order_xor ? ilv_lo : lin_lo;
endmodule

// File: rtl/addr_burst_gen.sv
module addr_burst_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              advance,
  input  logic              order_xor,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] burst_addr
);
  localparam int UP_W = ADDR_W - BEAT_W;

  logic [ADDR_W-1:0] start_q;
  beat_t             beat;
  beat_t             lo;

  burst_start_reg #(.ADDR_W(ADDR_W)) u_start (
    .clk(clk), .rst_n(rst_n), .capture(clk_en && !advance),
    .d(ext_addr), .q(start_q)
  );

  burst_beat_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .en(clk_en), .restart(!advance), .beat(beat)
  );

  burst_order_map u_map (
    .start_lo(start_q[BEAT_W-1:0]), .beat(beat),
    .order_xor(order_xor), .addr_lo(lo)
  );

  assign burst_addr = {start_q[ADDR_W-1 -: UP_W], lo};
endmodule

// File: rtl/addr_burst_gen_chk.sv
module addr_burst_gen_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en,
  input logic              advance,
  input logic              order_xor,
  input logic [ADDR_W-1:0] ext_addr,
  input logic [ADDR_W-1:0] burst_addr
);
  a_r2_load_takes_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !advance) |=> (order_xor != $past(order_xor) ||
                              burst_addr == $past(ext_addr)));

  a_r7_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en) |=> ($stable(burst_addr) || !$stable(order_xor)));

  a_r6_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && advance) |=> (burst_addr[ADDR_W-1:2] == $past(burst_addr[ADDR_W-1:2])));

  a_r3_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && advance && !order_xor) |=>
      (order_xor || burst_addr[1:0] == $past(burst_addr[1:0]) + 2'd1));
endmodule

bind addr_burst_gen addr_burst_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .advance(advance),
  .order_xor(order_xor), .ext_addr(ext_addr), .burst_addr(burst_addr)
);

// File: tb/addr_burst_gen_bench.sv
module addr_burst_gen_bench;
  localparam int AW = 20;
  localparam int NV = 18;
  // row: {clk_en, advance, order_xor, ext_addr, expected burst_addr}
  localparam logic [2*AW+2:0] VEC [NV] = '{
    {3'b100, 20'h12345, 20'h12345}, // R2 load, linear, start 1
    {3'b110, 20'h00000, 20'h12346}, // R3
    {3'b110, 20'h00000, 20'h12347}, // R3
    {3'b110, 20'h00000, 20'h12344}, // R3
    {3'b110, 20'h00000, 20'h12345}, // R5 wrap
    {3'b000, 20'hABCDE, 20'h12345}, // R7 load ignored
    {3'b010, 20'h00000, 20'h12345}, // R7 advance ignored
    {3'b101, 20'h0F0F1, 20'h0F0F1}, // R2 load, interleaved
    {3'b111, 20'h00000, 20'h0F0F0}, // R4
    {3'b111, 20'h00000, 20'h0F0F3}, // R4
    {3'b111, 20'h00000, 20'h0F0F2}, // R4
    {3'b111, 20'h00000, 20'h0F0F1}, // R5 wrap
    {3'b111, 20'h00000, 20'h0F0F0}, // R4 mid-burst
    {3'b101, 20'hFFFFE, 20'hFFFFE}, // R8 restart
    {3'b111, 20'h00000, 20'hFFFFF}, // R8 beat 1
    {3'b111, 20'h00000, 20'hFFFFC}, // R6 upper bits kept
    {3'b100, 20'h00003, 20'h00003}, // R2
    {3'b110, 20'h00000, 20'h00000}  // R6 no carry
  };

  logic          clk = 0;
  logic          rst_n = 0;
  logic          clk_en = 0, advance = 0, order_xor = 0;
  logic [AW-1:0] ext_addr = '0;
  logic [AW-1:0] burst_addr;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  addr_burst_gen #(.ADDR_W(AW)) u_addr_burst_gen (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .advance(advance),
    .order_xor(order_xor), .ext_addr(ext_addr), .burst_addr(burst_addr)
  );

  task automatic check(input string req, input logic [AW-1:0] exp);
    n_cmp++;
    if (burst_addr !== exp) begin
      n_bad++;
      $display("FAIL %s: burst_addr=%h expected=%h", req, burst_addr, exp);
    end
  endtask

  function automatic string req_of(input logic ce, input logic adv, input logic ox);
    if (!ce)       return "R7";
    else if (!adv) return "R2";
    else if (ox)   return "R4";
    else           return "R3";
  endfunction

  task automatic step(input logic ce, input logic adv, input logic ox,
                      input logic [AW-1:0] a);
    clk_en = ce; advance = adv; order_xor = ox; ext_addr = a;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", '0);
    rst_n = 1;
    @(negedge clk);
    check("R1", '0);
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][2*AW+2], VEC[i][2*AW+1], VEC[i][2*AW], VEC[i][2*AW-1:AW]);
      check(req_of(VEC[i][2*AW+2], VEC[i][2*AW+1], VEC[i][2*AW]), VEC[i][AW-1:0]);
    end
    // R8: linear restart mid-burst from start 2
    step(1, 0, 0, 20'h55552); check("R8", 20'h55552);
    step(1, 1, 0, 20'h0);     check("R3", 20'h55553);
    step(1, 0, 0, 20'h77771); check("R8", 20'h77771);
    step(1, 1, 0, 20'h0);     check("R8", 20'h77772);
    // R5: full interleaved cycle from start 3 returns to start
    step(1, 0, 1, 20'hA0003); check("R2", 20'hA0003);
    step(1, 1, 1, 20'h0);     check("R4", 20'hA0002);
    step(1, 1, 1, 20'h0);     check("R4", 20'hA0001);
    step(1, 1, 1, 20'h0);     check("R4", 20'hA0000);
    step(1, 1, 1, 20'h0);     check("R5", 20'hA0003);
    // R1: reset in the middle of a burst
    step(1, 1, 1, 20'h0);
    rst_n = 0;
    #1 check("R1", '0);
    @(negedge clk);
    rst_n = 1;
    step(0, 0, 0, 20'h0);     check("R1", '0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule